// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block steps an external analog-to-digital converter across a configurable set of input channels. Each result is stored in a scan data register for its channel, and a host can read that register at any time. The channel count is a static configuration input. When the input filter option is on, the count is raised to a floor of 16 channels.

There are two operating modes. Continuous scanning is the default after any reset. It needs no host setup: it converts channel 0 upward to the last channel and then wraps back to 0, forever. In single-pass poll mode, the sequencer waits for a start event. A start event is a pulse from an external periodic timer, or a start bit written by the host. The sequencer then converts every channel once, stops, and raises an end-of-scan status flag. A software reset bit in the control register holds the whole block in reset for as long as the bit stays set.

The converter link has two valid/ready streams. On the request stream, the sequencer offers a channel number. It holds `adc_req_valid` and `adc_ch` steady until `adc_req_ready` is seen high at a clock edge. On the result stream, the converter holds `adc_res_valid` and `adc_res_data` until the sequencer accepts them with `adc_res_ready`. The sequencer applies back-pressure to results only while it has a request outstanding on the request stream. It keeps at most one conversion in flight.

Top module: `adc_scan_seq`

## Requirements
- R1: While `rst_n` is low, the control/status word reads 0, and every scan data register reads 0.
- R2: Writing 1 to control bit 0 holds the block in reset until bit 0 is written back to 0. While held, no conversion is requested, status bits 13 and 14 read 0, and every scan data register reads 0.
- R3: With control bit 1 clear (the value after any reset), the sequencer starts converting with no host write and loops continuously.
- R4: Requested channels run 0, 1, …, last in order and then wrap to 0. A request that is not yet accepted keeps its channel stable.
- R5: Each accepted result overwrites the scan data register of its channel. A read at address `rd_addr` returns the latest value, and registers never written read 0.
- R6: The effective channel count is `cfg_chan_cnt` raised to 16 when `cfg_filt_en` is 1, then forced to 1 if it is 0, then capped at NCH_MAX.
- R7: In poll mode (control bit 1 set), a pass converts each channel exactly once. After the pass, requests stop and status bit 13 (end of scan) is set while bit 14 (busy) reads 0. Writing control bit 2 as 1 starts a pass.
- R8: A `tmr_start` pulse while idle in poll mode starts one pass. A start pulse that arrives while a pass runs is ignored.
- R9: End of scan clears when a new pass starts or on any control write. A control write alone starts no conversion in poll mode.
- R10: A read whose address matches the channel being written in the same cycle returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| cfg_chan_cnt | input | NW | Static channel count setting |
| cfg_filt_en | input | 1 | Filter option installed; enforces the 16-channel floor |
| csr_we | input | 1 | Control write strobe |
| csr_wdata | input | 16 | Control write data: bit0 soft reset, bit1 poll mode, bit2 start pass |
| csr_rdata | output | 16 | Status: bit0 soft reset, bit1 poll mode, bit13 end of scan, bit14 busy |
| rd_addr | input | CW | Scan data read address (channel) |
| rd_data | output | DW | Scan data read value |
| tmr_start | input | 1 | Start pulse from external timer |
| adc_req_valid | output | 1 | Conversion request valid |
| adc_req_ready | input | 1 | Converter accepts request |
| adc_ch | output | CW | Channel of the request |
| adc_res_valid | input | 1 | Conversion result valid |
| adc_res_ready | output | 1 | Sequencer accepts result |
| adc_res_data | input | DW | Conversion result |

## Verification
The assertions assume the following about the converter and the host:
- The converter returns exactly one result per accepted request.
- The host sets the soft reset bit only after a poll pass has finished, so no request or result is in flight when the bit is set.
- `cfg_chan_cnt` and `cfg_filt_en` change only while the soft reset bit is held.

The stimulus respects these limits. Its converter model holds request-ready low while a result is pending, and it returns one result after a random delay. Before every soft reset, the stimulus drives the block to end of scan, and it changes the configuration only inside the reset window. Start pulses during a pass are sent only after busy has been read as set, so they land while the pass is running.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CSR_W    = 16;
  localparam int BIT_SRST = 0;
  localparam int BIT_POLL = 1;
  localparam int BIT_GO   = 2;
  localparam int BIT_EOS  = 13;
  localparam int BIT_BUSY = 14;
  localparam int FILT_MIN = 16;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_WAIT
  } sq_state_t;
endpackage

// File: rtl/adc_scan_ctl.sv
module adc_scan_ctl
  import adc_scan_pkg::*;
#(
  parameter int NCH_MAX = 32,
  parameter int CW      = $clog2(NCH_MAX),
  parameter int NW      = CW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CSR_W-1:0] wdata,
  input  logic [NW-1:0]    cnt_raw,
  input  logic             filt_en,
  input  logic             eos,
  input  logic             busy,
  output logic             srst,
  output logic             poll,
  output logic             go,
  output logic [CW-1:0]    last_ch,
  output logic [CSR_W-1:0] rdata
);
  function automatic logic [CW-1:0] calc_last(logic [NW-1:0] raw, logic f);
    int n;
    n = int'(raw);
    if (f && n < FILT_MIN) n = FILT_MIN;
    if (n == 0) n = 1;
    if (n > NCH_MAX) n = NCH_MAX;
    return CW'(n - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst <= 1'b0;
      poll <= 1'b0;
    end else if (we) begin
      srst <= wdata[BIT_SRST];
      poll <= wdata[BIT_POLL];
    end
  end

  assign go      = we & wdata[BIT_GO] & ~wdata[BIT_SRST];
  assign last_ch = calc_last(cnt_raw, filt_en);

  always_comb begin
    rdata           = '0;
    rdata[BIT_SRST] = srst;
    rdata[BIT_POLL] = poll;
    rdata[BIT_EOS]  = eos & ~srst;
    rdata[BIT_BUSY] = busy & ~srst;
  end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int CW = 5,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          poll,
  input  logic          go,
  input  logic          tmr_start,
  input  logic          csr_wr,
  input  logic [CW-1:0] last_ch,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [CW-1:0] req_ch,
  input  logic          res_valid,
  output logic          res_ready,
  input  logic [DW-1:0] res_data,
  output logic          wr_en,
  output logic [CW-1:0] wr_ch,
  output logic [DW-1:0] wr_data,
  output logic          eos,
  output logic          busy
);
  sq_state_t     state;
  logic [CW-1:0] ch;
  logic          at_last;
  logic          start_evt;

  assign at_last   = (ch == last_ch);
  assign start_evt = go | tmr_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      ch    <= '0;
      eos   <= 1'b0;
    end else if (srst) begin
      state <= SQ_IDLE;
      ch    <= '0;
      eos   <= 1'b0;
    end else begin
      if (csr_wr) eos <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (!poll) begin
            state <= SQ_REQ;
            ch    <= '0;
          end else if (start_evt) begin
            state <= SQ_REQ;
            ch    <= '0;
            eos   <= 1'b0;
          end
        end
        SQ_REQ: begin
          if (req_ready) state <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (res_valid) begin
            if (at_last) begin
              ch <= '0;
              if (poll) begin
                state <= SQ_IDLE;
                eos   <= 1'b1;
              end else begin
                state <= SQ_REQ;
              end
            end else begin
              ch    <= ch + CW'(1);
              state <= SQ_REQ;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign req_valid = (state == SQ_REQ) & ~srst;
  assign req_ch    = ch;
  assign res_ready = (state != SQ_REQ);
  assign wr_en     = (state == SQ_WAIT) & res_valid & ~srst;
  assign wr_ch     = ch;
  assign wr_data   = res_data;
  assign busy      = (state != SQ_IDLE);
endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs #(
  parameter int NCH_MAX = 32,
  parameter int CW      = $clog2(NCH_MAX),
  parameter int DW      = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_ch,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [NCH_MAX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH_MAX; i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NCH_MAX; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_ch] <= wr_data;
    end
  end

  always_comb begin
    if (wr_en && (wr_ch == rd_addr)) rd_data = wr_data;
    else if (int'(rd_addr) < NCH_MAX) rd_data = mem[rd_addr];
    else rd_data = '0;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH_MAX = 32,
  parameter int DW      = 12,
  parameter int CW      = $clog2(NCH_MAX),
  parameter int NW      = CW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    cfg_chan_cnt,
  input  logic             cfg_filt_en,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  input  logic [CW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             tmr_start,
  output logic             adc_req_valid,
  input  logic             adc_req_ready,
  output logic [CW-1:0]    adc_ch,
  input  logic             adc_res_valid,
  output logic             adc_res_ready,
  input  logic [DW-1:0]    adc_res_data
);
  logic          srst, poll, go, eos, busy, wr_en;
  logic [CW-1:0] last_ch, wr_ch;
  logic [DW-1:0] wr_data;

  adc_scan_ctl #(.NCH_MAX(NCH_MAX), .CW(CW), .NW(NW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(csr_we), .wdata(csr_wdata),
    .cnt_raw(cfg_chan_cnt), .filt_en(cfg_filt_en), .eos(eos), .busy(busy),
    .srst(srst), .poll(poll), .go(go), .last_ch(last_ch), .rdata(csr_rdata)
  );

  adc_scan_fsm #(.CW(CW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .srst(srst), .poll(poll), .go(go),
    .tmr_start(tmr_start), .csr_wr(csr_we), .last_ch(last_ch),
    .req_valid(adc_req_valid), .req_ready(adc_req_ready), .req_ch(adc_ch),
    .res_valid(adc_res_valid), .res_ready(adc_res_ready), .res_data(adc_res_data),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data), .eos(eos), .busy(busy)
  );

  adc_scan_regs #(.NCH_MAX(NCH_MAX), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr(srst), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int NCH_MAX = 32,
  parameter int CW      = $clog2(NCH_MAX),
  parameter int NW      = CW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NW-1:0] cfg_chan_cnt,
  input logic          cfg_filt_en,
  input logic [15:0]   csr_rdata,
  input logic          adc_req_valid,
  input logic          adc_req_ready,
  input logic [CW-1:0] adc_ch
);
  int max_ch;
  always_comb begin
    max_ch = int'(cfg_chan_cnt);
    if (cfg_filt_en && max_ch < 16) max_ch = 16;
    if (max_ch == 0) max_ch = 1;
    if (max_ch > NCH_MAX) max_ch = NCH_MAX;
    max_ch = max_ch - 1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req_valid && !adc_req_ready |=> adc_req_valid && $stable(adc_ch)); // R4
  AST_CH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req_valid |-> int'(adc_ch) <= max_ch); // R6
  AST_EOS_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[13] |-> !adc_req_valid && !csr_rdata[14]); // R7
  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[0] |-> !adc_req_valid && !csr_rdata[13]); // R2
endmodule

bind adc_scan_seq adc_scan_chk #(.NCH_MAX(NCH_MAX), .CW(CW), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_chan_cnt(cfg_chan_cnt), .cfg_filt_en(cfg_filt_en),
  .csr_rdata(csr_rdata), .adc_req_valid(adc_req_valid),
  .adc_req_ready(adc_req_ready), .adc_ch(adc_ch)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
  localparam int NCH = 32;
  localparam int DW  = 12;
  localparam int CW  = 5;
  localparam int NW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] cfg_chan_cnt = NW'(6);
  logic cfg_filt_en = 1'b0;
  logic csr_we = 1'b0;
  logic [15:0] csr_wdata = '0;
  logic [15:0] csr_rdata;
  logic [CW-1:0] rd_addr, tst_addr = '0;
  logic [DW-1:0] rd_data;
  logic tmr_start = 1'b0;
  logic adc_req_valid, adc_res_ready;
  logic adc_req_ready = 1'b0;
  logic [CW-1:0] adc_ch;
  logic adc_res_valid = 1'b0;
  logic [DW-1:0] adc_res_data = '0;

  int checks = 0, fails = 0, conv_cnt = 0;
  int exp_ch = 0, exp_last = 5;
  logic [DW-1:0] exp_mem [NCH];
  bit pend = 0, acc = 0;
  logic [CW-1:0] pend_ch = '0;
  int dly = 0;

  always #2 clk = ~clk;

  assign rd_addr = pend ? pend_ch : tst_addr;

  adc_scan_seq #(.NCH_MAX(NCH), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_chan_cnt(cfg_chan_cnt), .cfg_filt_en(cfg_filt_en),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .tmr_start(tmr_start),
    .adc_req_valid(adc_req_valid), .adc_req_ready(adc_req_ready), .adc_ch(adc_ch),
    .adc_res_valid(adc_res_valid), .adc_res_ready(adc_res_ready),
    .adc_res_data(adc_res_data)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_cnt(int raw, bit f);
    int n = raw;
    if (f && n < 16) n = 16;
    if (n == 0) n = 1;
    if (n > NCH) n = NCH;
    return n;
  endfunction

  // behavioural converter
  initial begin
    forever begin
      @(negedge clk);
      if (acc) begin adc_res_valid = 1'b0; acc = 0; pend = 0; end
      if (pend && !adc_res_valid) begin
        if (dly == 0) begin adc_res_valid = 1'b1; adc_res_data = DW'($urandom); end
        else dly--;
      end
      adc_req_ready = !pend && ($urandom % 4 != 0);
      #1;
      if (adc_res_valid && adc_res_ready) begin
        chk(rd_data == adc_res_data, "R10", int'(rd_data), int'(adc_res_data));
        exp_mem[pend_ch] = adc_res_data;
        acc = 1;
      end
      if (adc_req_valid && adc_req_ready) begin
        chk(int'(adc_ch) == exp_ch, "R4", int'(adc_ch), exp_ch);
        pend = 1; pend_ch = adc_ch; dly = int'($urandom % 4); conv_cnt++;
        exp_ch = (exp_ch == exp_last) ? 0 : exp_ch + 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic csr_write(logic [15:0] v);
    @(negedge clk); csr_we = 1'b1; csr_wdata = v;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    @(negedge clk); tst_addr = CW'(a); #1; d = rd_data;
  endtask

  task automatic wait_eos(string req);
    int k = 0;
    do begin @(negedge clk); #1; k++; end while (!csr_rdata[13] && k < 4000);
    chk(csr_rdata[13] == 1'b1, req, int'(csr_rdata[13]), 1);
  endtask

  task automatic pulse_start();
    @(negedge clk); tmr_start = 1'b1;
    @(negedge clk); tmr_start = 1'b0; #1;
    chk(csr_rdata[13] == 1'b0 && csr_rdata[14] == 1'b1, "R9", int'(csr_rdata), 16'h4002);
  endtask

  task automatic extra_pulse();
    @(negedge clk); #1;
    if (csr_rdata[14]) tmr_start = 1'b1;
    @(negedge clk); tmr_start = 1'b0;
  endtask

  task automatic check_mem(int e, string req);
    logic [DW-1:0] d;
    for (int c = 0; c < NCH; c++) begin
      rd(c, d);
      if (c < e) chk(d == exp_mem[c], req, int'(d), int'(exp_mem[c]));
      else chk(d == '0, req, int'(d), 0);
    end
  endtask

  task automatic enter_cfg(int raw, bit f);
    csr_write(16'h0003);
    repeat (2) @(negedge clk);
    for (int c = 0; c < NCH; c++) exp_mem[c] = '0;
    cfg_chan_cnt = NW'(raw); cfg_filt_en = f;
    exp_last = eff_cnt(raw, f) - 1; exp_ch = 0;
    csr_write(16'h0002);
  endtask

  initial begin
    logic [DW-1:0] d;
    int c0, e, raw;
    bit f;
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) exp_mem[c] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(csr_rdata == 16'h0, "R1", int'(csr_rdata), 0);
    tst_addr = CW'(3); #1;
    chk(rd_data == '0, "R1", int'(rd_data), 0);
    @(negedge clk); rst_n = 1'b1;
    // R3: free-running scan after reset
    repeat (30) @(negedge clk);
    chk(conv_cnt > 0, "R3", conv_cnt, 1);
    c0 = 0;
    while (conv_cnt < 20 && c0 < 2000) begin @(negedge clk); c0++; end
    chk(conv_cnt >= 20, "R3", conv_cnt, 20);
    // switch to poll: current pass ends with end of scan
    csr_write(16'h0002);
    wait_eos("R7");
    chk(csr_rdata[14] == 1'b0, "R7", int'(csr_rdata[14]), 0);
    c0 = conv_cnt; repeat (40) @(negedge clk);
    chk(conv_cnt == c0, "R7", conv_cnt, c0);
    check_mem(6, "R5");
    // timer pass with ignored extra pulses
    c0 = conv_cnt;
    pulse_start();
    repeat (3) extra_pulse();
    wait_eos("R8");
    chk(conv_cnt - c0 == 6, "R8", conv_cnt - c0, 6);
    // control write clears end of scan, starts nothing
    csr_write(16'h0002); #1;
    chk(csr_rdata[13] == 1'b0, "R9", int'(csr_rdata[13]), 0);
    c0 = conv_cnt; repeat (20) @(negedge clk);
    chk(conv_cnt == c0, "R9", conv_cnt, c0);
    // host start bit
    csr_write(16'h0006);
    wait_eos("R7");
    chk(conv_cnt - c0 == 6, "R7", conv_cnt - c0, 6);
    // soft reset hold
    csr_write(16'h0003);
    repeat (2) @(negedge clk); #1;
    chk(csr_rdata == 16'h0003, "R2", int'(csr_rdata), 3);
    for (int c = 0; c < NCH; c++) exp_mem[c] = '0;
    check_mem(0, "R2");
    c0 = conv_cnt; repeat (30) @(negedge clk);
    chk(conv_cnt == c0, "R2", conv_cnt, c0);
    // count of zero -> one channel
    cfg_chan_cnt = '0; cfg_filt_en = 1'b0; exp_last = 0; exp_ch = 0;
    csr_write(16'h0002);
    c0 = conv_cnt; pulse_start(); wait_eos("R6");
    chk(conv_cnt - c0 == 1, "R6", conv_cnt - c0, 1);
    // filter floor
    enter_cfg(5, 1'b1);
    c0 = conv_cnt; pulse_start(); wait_eos("R6");
    chk(conv_cnt - c0 == 16, "R6", conv_cnt - c0, 16);
    check_mem(16, "R5");
    // randomised passes
    for (int it = 0; it < 6; it++) begin
      raw = int'($urandom % 40); f = 1'($urandom % 2);
      e = eff_cnt(raw, f);
      enter_cfg(raw, f);
      c0 = conv_cnt; pulse_start();
      repeat ($urandom % 3) extra_pulse();
      wait_eos("R8");
      chk(conv_cnt - c0 == e, "R8", conv_cnt - c0, e);
      check_mem(e, "R5");
    end
    // back to continuous
    c0 = conv_cnt;
    csr_write(16'h0000);
    e = exp_last + 1;
    repeat (20 * e + 40) @(negedge clk);
    chk(conv_cnt - c0 >= 2 * e, "R3", conv_cnt - c0, 2 * e);
    csr_write(16'h0002);
    wait_eos("R7");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule